// File: doc/BRIEF.md
# Single-Port RAM with Selectable Write Policy

This block is a synchronous single-port memory built from a plain array. One clock drives everything. An access enable gates both reading and writing. A write enable, an address and a data word complete the access, and a registered data output returns the result. On an enabled read, the output shows the addressed word after the clock edge. On an enabled write, a compile-time policy decides what the output shows: the word being written, the word the write is replacing, or the previous output, left untouched.

An optional second register can follow the output. It costs one extra cycle of read latency and helps timing on the read path. This register has its own update enable and its own synchronous clear. The clear never reaches the array.

Each clock, the output stage decodes the access into one of three states: `ACC_IDLE` (enable low), `ACC_READ` (enable high, write enable low) or `ACC_WRITE` (both high). It then applies the action for that state. The state is chosen fresh every clock from the inputs, so any state can follow any other. `ACC_IDLE` holds the output, `ACC_READ` loads the stored word, and `ACC_WRITE` applies the configured policy.

Top module: `spram_wmode`

## Requirements
- R1: With `WR_POLICY` = 0 (new-data policy, the default), an enabled write stores `wr_data` and shows that same word on the output after the clock edge.
- R2: With `WR_POLICY` = 1 (old-data policy), an enabled write shows the word that the address held before the edge, and stores the new word.
- R3: With `WR_POLICY` = 2 (hold policy), an enabled write leaves the output unchanged, and still updates the stored word.
- R4: With `OUT_REG` = 0, an enabled read shows the addressed word one clock after the address is presented.
- R5: While `acc_en` is low, nothing is stored even if `wr_en` is high, and the output keeps its value.
- R6: The output and every stored word start at zero before the first access.
- R7: With `OUT_REG` = 1, the output is the first-stage value delayed by one clock, and it updates only on edges where `oreg_ce` is high.
- R8: With `OUT_REG` = 1, `oreg_clr` high clears the output register to zero on the next edge and takes priority over `oreg_ce`. It leaves the stored words untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| acc_en | input | 1 | Access enable; gates both read and write |
| wr_en | input | 1 | Write enable (1 = write, 0 = read) |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Word to store |
| oreg_ce | input | 1 | Update enable of the optional output register |
| oreg_clr | input | 1 | Synchronous clear of the optional output register |
| rd_data | output | DATA_W | Registered data output |

## Verification
The bench builds six copies that share one stimulus stream, one for each pairing of the three write policies with the output register present or absent. The data width is 16 and the address width is 10. With the copies side by side, every policy difference shows up in the same cycle: a write to a freshly read address, a write immediately followed by a read, and a write attempted while the access enable is low. The registered copies also bring the update-enable hold and the clear-over-enable priority within reach, and they show that a clear leaves the array intact. Addresses 0 and 1023 cover both ends of the array.

// File: rtl/spram_pkg.sv
package spram_pkg;

    // Output policy applied on a write cycle
    typedef enum logic [1:0] {
        WM_NEW  = 2'd0,
        WM_OLD  = 2'd1,
        WM_HOLD = 2'd2
    } wmode_e;

    // Access kind decoded each clock
    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE
    } acc_e;

endpackage

// File: rtl/spram_store.sv
module spram_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cur_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (wr_go) mem[addr] <= wr_data;
    end

    // word currently held at the address, before this edge's write
    assign cur_word = mem[addr];

endmodule

// File: rtl/spram_outsel.sv
module spram_outsel
    import spram_pkg::*;
#(
    parameter int     DATA_W    = 16,
    parameter wmode_e WR_POLICY = WM_NEW
) (
    input  logic              clk,
    input  logic              acc_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] cur_word,
    output logic [DATA_W-1:0] lat_q
);
    acc_e              acc_kind;
    logic [DATA_W-1:0] lat_r = '0;
    logic [DATA_W-1:0] lat_nxt;

    // access decode
    always_comb begin
        if (!acc_en)     acc_kind = ACC_IDLE;
        else if (!wr_en) acc_kind = ACC_READ;
        else             acc_kind = ACC_WRITE;
    end

    // next output per access kind and policy
    always_comb begin
        lat_nxt = lat_r;
        unique case (acc_kind)
            ACC_IDLE:  lat_nxt = lat_r;
            ACC_READ:  lat_nxt = cur_word;
            ACC_WRITE: begin
                unique case (WR_POLICY)
                    WM_NEW:  lat_nxt = wr_data;
                    WM_OLD:  lat_nxt = cur_word;
                    WM_HOLD: lat_nxt = lat_r;
                    default: lat_nxt = wr_data;
                endcase
            end
            default:   lat_nxt = lat_r;
        endcase
    end

    always_ff @(posedge clk) begin
        lat_r <= lat_nxt;
    end

    assign lat_q = lat_r;

    logic chk_armed = 1'b0;
    always_ff @(posedge clk) chk_armed <= 1'b1;

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!chk_armed)
        !acc_en |=> $stable(lat_q));

    // R4
    read_word_chk: assert property (@(posedge clk) disable iff (!chk_armed)
        (acc_en && !wr_en) |=> (lat_q == $past(cur_word)));

    generate
        if (WR_POLICY == WM_NEW) begin : g_new
            // R1
            wr_new_chk: assert property (@(posedge clk) disable iff (!chk_armed)
                (acc_en && wr_en) |=> (lat_q == $past(wr_data)));
        end else if (WR_POLICY == WM_OLD) begin : g_old
            // R2
            wr_old_chk: assert property (@(posedge clk) disable iff (!chk_armed)
                (acc_en && wr_en) |=> (lat_q == $past(cur_word)));
        end else begin : g_hold
            // R3
            wr_hold_chk: assert property (@(posedge clk) disable iff (!chk_armed)
                (acc_en && wr_en) |=> $stable(lat_q));
        end
    endgenerate

endmodule

// File: rtl/spram_pipe.sv
module spram_pipe #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              ce,
    input  logic              clr,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] q_r = '0;

    always_ff @(posedge clk) begin
        if (clr)     q_r <= '0;
        else if (ce) q_r <= d;
    end

    assign q = q_r;

    logic chk_armed = 1'b0;
    always_ff @(posedge clk) chk_armed <= 1'b1;

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!chk_armed)
        clr |=> (q == '0));

    // R7
    ce_hold_chk: assert property (@(posedge clk) disable iff (!chk_armed)
        (!clr && !ce) |=> $stable(q));

    // R7
    ce_load_chk: assert property (@(posedge clk) disable iff (!chk_armed)
        (!clr && ce) |=> (q == $past(d)));

endmodule

// File: rtl/spram_wmode.sv
module spram_wmode
    import spram_pkg::*;
#(
    parameter int     DATA_W    = 16,
    parameter int     ADDR_W    = 10,
    parameter wmode_e WR_POLICY = WM_NEW,
    parameter bit     OUT_REG   = 1'b1
) (
    input  logic              clk,
    input  logic              acc_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              oreg_ce,
    input  logic              oreg_clr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] lat_q;
    logic              wr_go;

    assign wr_go = acc_en & wr_en;

    spram_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .wr_go(wr_go), .addr(addr),
        .wr_data(wr_data), .cur_word(cur_word)
    );

    spram_outsel #(.DATA_W(DATA_W), .WR_POLICY(WR_POLICY)) u_outsel (
        .clk(clk), .acc_en(acc_en), .wr_en(wr_en),
        .wr_data(wr_data), .cur_word(cur_word), .lat_q(lat_q)
    );

    generate
        if (OUT_REG) begin : g_oreg
            spram_pipe #(.DATA_W(DATA_W)) u_pipe (
                .clk(clk), .ce(oreg_ce), .clr(oreg_clr),
                .d(lat_q), .q(rd_data)
            );
        end else begin : g_direct
            logic unused_oreg;
            assign unused_oreg = oreg_ce ^ oreg_clr;
            assign rd_data = lat_q;
        end
    endgenerate

endmodule

// File: tb/test_spram_wmode.sv
module test_spram_wmode;
    import spram_pkg::*;

    localparam int DW = 16;
    localparam int AW = 10;
    localparam int NI = 6;   // 0..2 direct, 3..5 registered; policy = idx % 3

    logic          clk = 1'b0;
    logic          acc_en = 1'b0, wr_en = 1'b0, oreg_ce = 1'b0, oreg_clr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] dout [NI];

    always #10 clk = ~clk;   // 50 MHz

    genvar g;
    generate
        for (g = 0; g < NI; g++) begin : g_dut
            spram_wmode #(
                .DATA_W(DW), .ADDR_W(AW),
                .WR_POLICY(wmode_e'(g % 3)), .OUT_REG(g >= 3)
            ) i_spram_wmode (
                .clk(clk), .acc_en(acc_en), .wr_en(wr_en), .addr(addr),
                .wr_data(wr_data), .oreg_ce(oreg_ce), .oreg_clr(oreg_clr),
                .rd_data(dout[g])
            );
        end
    endgenerate

    // reference model
    int    refmem [1 << AW];
    int    exp_lat [3];
    int    exp_pipe [3];
    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R6";

    initial begin
        for (int i = 0; i < (1 << AW); i++) refmem[i] = 0;
        for (int k = 0; k < 3; k++) begin exp_lat[k] = 0; exp_pipe[k] = 0; end
    end

    always @(posedge clk) begin
        int old;
        old = refmem[addr];
        for (int k = 0; k < 3; k++) begin
            if (oreg_clr) exp_pipe[k] = 0;
            else if (oreg_ce) exp_pipe[k] = exp_lat[k];
        end
        for (int k = 0; k < 3; k++) begin
            if (acc_en) begin
                if (!wr_en) exp_lat[k] = old;
                else if (k == 0) exp_lat[k] = int'(wr_data);
                else if (k == 1) exp_lat[k] = old;
            end
        end
        if (acc_en && wr_en) refmem[addr] = int'(wr_data);
    end

    task automatic compare_all();
        for (int i = 0; i < NI; i++) begin
            int exp_v;
            exp_v = (i < 3) ? exp_lat[i] : exp_pipe[i - 3];
            n_cmp++;
            if (int'(dout[i]) != exp_v) begin
                n_bad++;
                $display("FAIL %s inst%0d: got %h expected %h", cur_req, i, dout[i], exp_v[DW-1:0]);
            end
        end
    endtask

    task automatic step(input logic e, input logic w, input int a, input int d,
                        input logic ce, input logic clr, input string req);
        @(negedge clk);
        compare_all();
        cur_req = req;
        acc_en = e; wr_en = w; addr = AW'(a); wr_data = DW'(d);
        oreg_ce = ce; oreg_clr = clr;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R6: reset state compared on first step
        step(0, 0, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, 1, 0, "R6");
        // R5: disabled cycle, write attempt ignored
        step(0, 1, 'h0AA, 'h1111, 1, 0, "R5");
        step(1, 0, 'h0AA, 0, 1, 0, "R4");          // read: must still be 0
        step(1, 0, 'h0AA, 0, 1, 0, "R4");
        // R1 R2 R3: writes to new addresses
        step(1, 1, 'h0BB, 'h1111, 1, 0, "R1");
        step(1, 1, 'h0CC, 'h2222, 1, 0, "R2");
        step(1, 0, 'h0BB, 0, 1, 0, "R4");
        step(1, 0, 'h0CC, 0, 1, 0, "R4");
        // R2: overwrite shows old word; R3 holds
        step(1, 1, 'h0BB, 'h3333, 1, 0, "R2");
        step(1, 0, 'h0BB, 0, 1, 0, "R3");           // memory updated in hold mode too
        step(0, 0, 'h0BB, 0, 1, 0, "R5");
        // boundary addresses
        step(1, 1, 0, 'hA5A5, 1, 0, "R1");
        step(1, 1, 1023, 'h5A5A, 1, 0, "R1");
        step(1, 0, 0, 0, 1, 0, "R4");
        step(1, 0, 1023, 0, 1, 0, "R4");
        // R7: output register enable low holds
        step(1, 0, 'h0CC, 0, 0, 0, "R7");
        step(1, 1, 'h0DD, 'h4444, 0, 0, "R7");
        step(1, 0, 'h0DD, 0, 0, 0, "R7");
        step(1, 0, 'h0DD, 0, 1, 0, "R7");
        // R8: clear wins over enable, memory untouched
        step(1, 0, 'h0BB, 0, 1, 1, "R8");
        step(1, 0, 'h0BB, 0, 1, 1, "R8");
        step(1, 0, 'h0BB, 0, 1, 0, "R8");
        step(0, 0, 'h0BB, 0, 1, 0, "R8");
        step(0, 0, 'h0BB, 0, 1, 0, "R8");
        // R5: disabled write over a known word, then read back
        step(0, 1, 'h0DD, 'hFFFF, 1, 0, "R5");
        step(1, 0, 'h0DD, 0, 1, 0, "R5");
        step(0, 0, 0, 0, 1, 0, "R5");
        // mixed traffic
        begin
            int s;
            s = 32'h1D2C3B4A;
            for (int n = 0; n < 300; n++) begin
                s = s * 1103515245 + 12345;
                step(s[20] | s[21], s[22], int'(s[13:10]) * 61, int'(s[31:16]),
                     s[23] | s[24], (s[25] & s[26] & s[27]), "R4");
            end
        end
        step(0, 0, 0, 0, 0, 0, "R5");
        @(negedge clk);
        compare_all();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule